// File: doc/BRIEF.md
# Transmit Ethernet Frame Builder

This block sits between a user packet source and the transmit physical coding logic of a 25G-class Ethernet port. It takes user packets of 1 to 9014 bytes on a 64-bit AXI4-Stream slave and sends each one out as an Ethernet frame on a 64-bit output stream. The output stream has a per-byte keep and a last flag, and it cannot be stalled. Packets shorter than 60 bytes are extended with zero bytes. A CRC-32 frame check sequence is appended straight after the payload, packed into the same beat when there is room for it.

The block holds no input buffer, so a packet must arrive as an unbroken run of beats. After each packet it drops tready for a fixed gap, which leaves the downstream logic room for delimiters and inter-frame idles. The gap grows for short packets and for packets that break the input rules. Rule breaks are reported on an 8-bit error vector. A packet with a broken handshake or a broken keep is still sent, but its check sequence is inverted so that the receiver discards it. The user can also cancel a packet on purpose by raising tuser on its last beat.

Top module: `eth_tx_framer`

## Requirements
- R1: tready is 0 during reset and while linkup is low. When linkup is sampled high at a clock edge, tready is 1 in the cycle that follows that edge, and no output beat is produced while linkup is low.
- R2: The output frame carries the user bytes in arrival order, with tkeep bit i selecting tdata bits [8i+7:8i], and the first byte of the frame in lane 0. Output keep is always a contiguous run starting at lane 0, out_last marks the final beat, and each accepted input beat appears on the output in the cycle after it is accepted.
- R3: A packet of L < 60 bytes is followed by 60 − L zero bytes before the check sequence. A packet of 60 bytes or more gets no padding.
- R4: The check sequence is the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, final value inverted) over the user and pad bytes. It is sent as 4 bytes, least significant byte first, directly after the last data or pad byte.
- R5: For a packet of 60 bytes or more with no rule break, tready is 0 for exactly GAP_CYCLES cycles (default 3, allowed 3 or 7), starting in the cycle after the last beat is accepted.
- R6: For a packet of L < 60 bytes that took n beats to transfer, the tready gap is lengthened by 8 − n cycles.
- R7: The error vector is updated to describe a packet two cycles after that packet's last beat is accepted, and it holds that value until the next update. Bits 7:4 are always 0, and reset clears the vector.
- R8: Bit 0 is set when tvalid is low in a cycle with tready high after a packet has started and before its last beat.
- R9: Bit 1 is set when a beat that is not the last has tkeep other than 0xFF. Such a beat still contributes all 8 of its bytes.
- R10: Bit 2 is set when the last beat's tkeep is not one of 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F or 0xFF. The last beat then contributes lanes 0 up to and including its highest set keep bit.
- R11: Bit 3 is set when the packet has more than 9014 bytes. The frame is still sent with a correct check sequence.
- R12: When bit 0 or bit 1 is set, or tuser is 1 on the last beat, the 4 check bytes are the bitwise inverse of the correct ones.
- R13: When any of bits 3:0 is set for a packet, its tready gap is one cycle longer than R5 and R6 give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| linkup | input | 1 | Link is up; gates tready |
| s_tdata | input | 64 | User packet data, lane 0 in bits 7:0 |
| s_tkeep | input | 8 | Byte qualifiers for s_tdata |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Last beat of the packet |
| s_tuser | input | 1 | Cancel request, sampled on the last beat |
| s_tready | output | 1 | Block accepts a beat |
| m_tdata | output | 64 | Frame data, lane 0 first |
| m_tkeep | output | 8 | Frame byte qualifiers |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Final beat of the frame |
| tx_err | output | 8 | Per-packet rule-break report |

## Verification
The hardest states to reach are the ones where the check sequence straddles beats or sits in the same beat as the last user bytes, and the ones where a broken packet also needs padding, because these only appear at particular lengths and fault positions. The stimulus walks directed lengths around the 60-byte pad edge and around every last-beat fill. It also sends one packet just over the size limit. Random lengths, random tuser, and faults injected at chosen beats (an idle cycle, a short keep on a middle beat, a keep with a hole on the last beat) are then mixed in. Every frame is rebuilt byte by byte in the bench and compared, and the gap length and error vector are checked for every packet.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Per-packet rule-break flags; drop lands in bit 0 of the report.
  typedef struct packed {
    logic oversize;
    logic last_keep;
    logic mid_keep;
    logic drop;
  } viol_t;

  // One byte through the reflected CRC-32, data taken LSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc,
                                             input logic [7:0]  din);
    logic [31:0] r;
    r = crc;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ din[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_beat_build.sv
module eth_tx_beat_build
  import eth_tx_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int POS_W       = 15,
  parameter int LW          = 4,
  parameter int MIN_PAYLOAD = 60
) (
  input  logic [POS_W-1:0]   base_i,
  input  logic [LW-1:0]      user_lanes_i,
  input  logic [POS_W-1:0]   user_len_i,
  input  logic [31:0]        crc_i,
  input  logic [LANES*8-1:0] data_i,
  input  logic               invert_i,
  output logic [LANES*8-1:0] data_o,
  output logic [LANES-1:0]   keep_o,
  output logic [31:0]        crc_o,
  output logic               final_o
);

  localparam int FCS_BYTES = 4;

  logic [POS_W-1:0] padded_len;
  logic [POS_W-1:0] frame_len;
  logic [31:0]      chain [LANES+1];
  logic [31:0]      fcs_word;

  assign padded_len = (user_len_i < POS_W'(MIN_PAYLOAD)) ? POS_W'(MIN_PAYLOAD) : user_len_i;
  assign frame_len  = padded_len + POS_W'(FCS_BYTES);
  assign chain[0]   = crc_i;
  assign crc_o      = chain[LANES];
  // Check lanes never feed the chain, so its tail is the final remainder.
  assign fcs_word   = invert_i ? chain[LANES] : ~chain[LANES];
  assign final_o    = ({1'b0, base_i} + (POS_W+1)'(LANES)) >= {1'b0, frame_len};

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [POS_W-1:0] idx;
      logic [1:0]       fcs_off;
      logic             is_user;
      logic             is_pad;
      logic             is_fcs;
      logic [7:0]       src;

      assign idx      = base_i + POS_W'(j);
      assign is_user  = LW'(j) < user_lanes_i;
      assign is_pad   = !is_user && (idx < padded_len);
      assign is_fcs   = !is_user && !is_pad && (idx < frame_len);
      assign fcs_off  = idx[1:0] - padded_len[1:0];
      assign src      = is_user ? data_i[8*j +: 8] : 8'h00;
      assign chain[j+1] = (is_user || is_pad) ? crc32_byte(chain[j], src) : chain[j];
      assign keep_o[j]  = is_user | is_pad | is_fcs;
      assign data_o[8*j +: 8] = is_fcs ? fcs_word[{fcs_off, 3'b000} +: 8] : src;
    end
  endgenerate

endmodule

// File: rtl/eth_tx_proto_check.sv
module eth_tx_proto_check
  import eth_tx_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int POS_W     = 15,
  parameter int MAX_BYTES = 9014
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [LANES-1:0] in_keep,
  input  logic             in_user,
  input  logic             tready,
  input  logic [POS_W-1:0] pkt_len,
  output logic             in_pkt,
  output logic             last_accept,
  output logic             corrupt,
  output logic             any_err,
  output logic [3:0]       beats,
  output logic [7:0]       err_vec
);

  logic       accept;
  logic       in_pkt_q, in_pkt_n;
  logic       drop_q, drop_n;
  logic       midk_q, midk_n;
  logic [3:0] beats_q, beats_n;
  logic       rep_vld_q;
  viol_t      rep_q, viol_cur;
  logic [7:0] err_q;
  logic       mid_now, drop_now, last_legal;

  assign accept      = in_valid & tready;
  assign last_accept = accept & in_last;
  assign mid_now     = accept & ~in_last & (in_keep != '1);
  assign drop_now    = in_pkt_q & ~in_valid & tready;
  assign last_legal  = (in_keep != '0) && (((in_keep + LANES'(1)) & in_keep) == '0);

  always_comb begin
    viol_cur.drop      = drop_q;
    viol_cur.mid_keep  = midk_q | mid_now;
    viol_cur.last_keep = ~last_legal;
    viol_cur.oversize  = pkt_len > POS_W'(MAX_BYTES);
  end

  assign corrupt = viol_cur.drop | viol_cur.mid_keep | in_user;
  assign any_err = |viol_cur;
  assign beats   = (beats_q == 4'hF) ? beats_q : beats_q + 4'd1;
  assign in_pkt  = in_pkt_q;
  assign err_vec = err_q;

  always_comb begin
    in_pkt_n = in_pkt_q;
    drop_n   = drop_q | drop_now;
    midk_n   = midk_q;
    beats_n  = beats_q;
    if (last_accept) begin
      in_pkt_n = 1'b0;
      drop_n   = 1'b0;
      midk_n   = 1'b0;
      beats_n  = '0;
    end else if (accept) begin
      in_pkt_n = 1'b1;
      midk_n   = midk_q | mid_now;
      beats_n  = beats;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      drop_q    <= 1'b0;
      midk_q    <= 1'b0;
      beats_q   <= '0;
      rep_vld_q <= 1'b0;
      rep_q     <= '0;
      err_q     <= '0;
    end else begin
      in_pkt_q  <= in_pkt_n;
      drop_q    <= drop_n;
      midk_q    <= midk_n;
      beats_q   <= beats_n;
      rep_vld_q <= last_accept;
      if (last_accept) rep_q <= viol_cur;
      if (rep_vld_q)   err_q <= {4'b0000, rep_q};
    end
  end

  assert_report_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_vld_q |=> $stable(err_vec));
  assert_report_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(last_accept) |=> (err_vec[3:0] == $past(rep_q)));
  assert_drop_in_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_q) |-> $past(in_pkt_q));

endmodule

// File: rtl/eth_tx_gap_ctl.sv
module eth_tx_gap_ctl #(
  parameter int GAP_CYCLES = 3,
  parameter int MIN_BEATS  = 8,
  parameter int CNT_W      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       linkup,
  input  logic       last_accept,
  input  logic [3:0] beats,
  input  logic       short_pkt,
  input  logic       any_err,
  output logic       tready
);

  logic             link_q;
  logic [CNT_W-1:0] gap_q, gap_n;
  logic [CNT_W-1:0] pad_extra;
  logic [CNT_W-1:0] gap_len;

  assign pad_extra = (short_pkt && (beats < 4'(MIN_BEATS))) ?
                     CNT_W'(4'(MIN_BEATS) - beats) : '0;
  assign gap_len   = CNT_W'(GAP_CYCLES) + pad_extra + CNT_W'(any_err);
  assign tready    = link_q & (gap_q == '0);

  always_comb begin
    if (last_accept)      gap_n = gap_len;
    else if (gap_q != '0) gap_n = gap_q - CNT_W'(1);
    else                  gap_n = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      link_q <= linkup;
      gap_q  <= gap_n;
    end
  end

  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> !tready);
  assert_link_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(linkup) |-> !tready);

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int MIN_PAYLOAD = 60,
  parameter int MAX_BYTES   = 9014,
  parameter int GAP_CYCLES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              linkup,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [DATA_W/8-1:0] s_tkeep,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  input  logic              s_tuser,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic              m_tvalid,
  output logic              m_tlast,
  output logic [7:0]        tx_err
);

  localparam int LANES     = DATA_W / 8;
  localparam int LW        = $clog2(LANES + 1);
  localparam int POS_W     = $clog2(MAX_BYTES + MIN_PAYLOAD + 4 * LANES) + 1;
  localparam int MIN_BEATS = (MIN_PAYLOAD + 4 + LANES - 1) / LANES;
  localparam int CNT_W     = $clog2(GAP_CYCLES + MIN_BEATS + 2) + 1;

  // Reset: asserted at once, released after two clean edges.
  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic             accept;
  logic             in_pkt, last_accept, corrupt, any_err;
  logic [3:0]       beats;
  logic [LW-1:0]    span;
  logic [POS_W-1:0] pkt_len;

  logic             tail_q, tail_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [POS_W-1:0] tlen_q, tlen_n;
  logic             tinv_q, tinv_n;
  logic [31:0]      crc_q, crc_n;

  logic [POS_W-1:0]  b_base, b_len;
  logic [LW-1:0]     b_lanes;
  logic [31:0]       b_crc_in, b_crc_out;
  logic              b_inv, b_final;
  logic [DATA_W-1:0] b_data;
  logic [LANES-1:0]  b_keep;

  logic              ov_n, ol_n;

  assign accept = s_tvalid & s_tready;

  always_comb begin
    span = '0;
    for (int i = 0; i < LANES; i++)
      if (s_tkeep[i]) span = LW'(i + 1);
  end

  assign pkt_len = (in_pkt ? pos_q : '0) + POS_W'(span);

  eth_tx_proto_check #(
    .LANES(LANES), .POS_W(POS_W), .MAX_BYTES(MAX_BYTES)
  ) u_check (
    .clk(clk), .rst_n(rst_int),
    .in_valid(s_tvalid), .in_last(s_tlast), .in_keep(s_tkeep), .in_user(s_tuser),
    .tready(s_tready), .pkt_len(pkt_len),
    .in_pkt(in_pkt), .last_accept(last_accept), .corrupt(corrupt),
    .any_err(any_err), .beats(beats), .err_vec(tx_err)
  );

  eth_tx_gap_ctl #(
    .GAP_CYCLES(GAP_CYCLES), .MIN_BEATS(MIN_BEATS), .CNT_W(CNT_W)
  ) u_gap (
    .clk(clk), .rst_n(rst_int), .linkup(linkup),
    .last_accept(last_accept), .beats(beats),
    .short_pkt(pkt_len < POS_W'(MIN_PAYLOAD)), .any_err(any_err),
    .tready(s_tready)
  );

  // Tail beats reuse the same lane builder with no user lanes.
  always_comb begin
    if (tail_q) begin
      b_base   = pos_q;
      b_lanes  = '0;
      b_len    = tlen_q;
      b_crc_in = crc_q;
      b_inv    = tinv_q;
    end else begin
      b_base   = in_pkt ? pos_q : '0;
      b_lanes  = s_tlast ? span : LW'(LANES);
      b_len    = pkt_len;
      b_crc_in = in_pkt ? crc_q : '1;
      b_inv    = corrupt;
    end
  end

  eth_tx_beat_build #(
    .LANES(LANES), .POS_W(POS_W), .LW(LW), .MIN_PAYLOAD(MIN_PAYLOAD)
  ) u_build (
    .base_i(b_base), .user_lanes_i(b_lanes), .user_len_i(b_len),
    .crc_i(b_crc_in), .data_i(s_tdata), .invert_i(b_inv),
    .data_o(b_data), .keep_o(b_keep), .crc_o(b_crc_out), .final_o(b_final)
  );

  always_comb begin
    tail_n = tail_q;
    pos_n  = pos_q;
    tlen_n = tlen_q;
    tinv_n = tinv_q;
    crc_n  = crc_q;
    ov_n   = 1'b0;
    ol_n   = 1'b0;
    if (tail_q) begin
      ov_n  = 1'b1;
      ol_n  = b_final;
      pos_n = pos_q + POS_W'(LANES);
      crc_n = b_crc_out;
      if (b_final) tail_n = 1'b0;
    end else if (accept) begin
      ov_n  = 1'b1;
      ol_n  = s_tlast & b_final;
      pos_n = b_base + POS_W'(LANES);
      crc_n = b_crc_out;
      if (s_tlast && !b_final) begin
        tail_n = 1'b1;
        tlen_n = pkt_len;
        tinv_n = corrupt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      tail_q   <= 1'b0;
      pos_q    <= '0;
      tlen_q   <= '0;
      tinv_q   <= 1'b0;
      crc_q    <= '1;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      m_tdata  <= '0;
      m_tkeep  <= '0;
    end else begin
      tail_q   <= tail_n;
      pos_q    <= pos_n;
      tlen_q   <= tlen_n;
      tinv_q   <= tinv_n;
      crc_q    <= crc_n;
      m_tvalid <= ov_n;
      m_tlast  <= ol_n;
      if (ov_n) begin
        m_tdata <= b_data;
        m_tkeep <= b_keep;
      end
    end
  end

  assert_keep_packed_R2: assert property (@(posedge clk) disable iff (!rst_int)
    m_tvalid |-> (m_tkeep != '0) && (((m_tkeep + LANES'(1)) & m_tkeep) == '0));
  assert_tail_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_int)
    tail_q |-> !(s_tvalid && s_tready));
  assert_beat_follows_R2: assert property (@(posedge clk) disable iff (!rst_int)
    accept |=> m_tvalid);
  assert_no_out_linkdown_R1: assert property (@(posedge clk) disable iff (!rst_int)
    (!$past(linkup) && !$past(tail_q)) |=> !m_tvalid);

endmodule

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        linkup;
  logic [63:0] s_tdata;
  logic [7:0]  s_tkeep;
  logic        s_tvalid, s_tlast, s_tuser;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        m_tvalid, m_tlast;
  logic [7:0]  tx_err;

  always #2 clk = ~clk;

  eth_tx_framer #(.GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .linkup(linkup),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tuser(s_tuser), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .tx_err(tx_err)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] pkt   [9200];
  logic [7:0] exp_f [9200];
  logic [7:0] got   [9200];
  int got_n = 0;
  int frame_len = 0;
  int frames_seen = 0;

  always @(negedge clk) begin
    if (m_tvalid) begin
      for (int j = 0; j < 8; j++)
        if (m_tkeep[j]) begin
          got[got_n] = m_tdata[8*j +: 8];
          got_n++;
        end
      if (m_tlast) begin
        frame_len = got_n;
        frames_seen++;
      end
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ exp_f[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  // drop_beat > 0: idle cycle inserted before that beat; bad_beat >= 0: keep 0x0F there.
  task automatic send(input int len, input int drop_beat, input int bad_beat,
                      input logic [7:0] ovr_keep, input logic usr, input string etag);
    int nb = (len + 7) / 8;
    int k  = len - 8 * (nb - 1);
    logic [7:0] lkeep;
    int span = 0;
    int L, PL, F, expg, low, kk, t, prev, bad, first_bad;
    logic e_drop, e_mid, e_last, e_over, corr, anyerr;
    logic [7:0] errv = 8'hxx;
    logic [31:0] fcs;
    string gtag, ftag;
    lkeep = (ovr_keep != 0) ? ovr_keep : 8'((9'd1 << k) - 9'd1);
    for (int i = 0; i < 8; i++) if (lkeep[i]) span = i + 1;
    L = 8 * (nb - 1) + span;
    e_drop = drop_beat > 0;
    e_mid  = bad_beat >= 0 && bad_beat < nb - 1;
    e_last = !(lkeep != 0 && ((lkeep + 8'd1) & lkeep) == 0);
    e_over = L > 9014;
    corr   = e_drop | e_mid | usr;
    anyerr = e_drop | e_mid | e_last | e_over;
    for (int i = 0; i < nb * 8; i++) pkt[i] = 8'($urandom);
    got_n = 0;
    prev = frames_seen;
    for (int b = 0; b < nb; b++) begin
      if (b == drop_beat) begin
        s_tvalid = 1'b0;
        @(negedge clk);
      end
      for (int j = 0; j < 8; j++) s_tdata[8*j +: 8] = pkt[8*b + j];
      s_tkeep  = (b == nb - 1) ? lkeep : ((b == bad_beat) ? 8'h0F : 8'hFF);
      s_tlast  = (b == nb - 1);
      s_tuser  = usr && (b == nb - 1);
      s_tvalid = 1'b1;
      t = 0;
      while (!s_tready && t < 100) begin @(negedge clk); t++; end
      @(posedge clk);
      @(negedge clk);
      if (b == 0 && L > 0)  // R2: beat visible one cycle after acceptance
        check(m_tvalid && m_tdata[7:0] == pkt[0], "R2 first beat timing", m_tdata[7:0], pkt[0]);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = 1'b0;
    low = 0; kk = 1;
    while (kk < 64) begin
      if (kk == 2) errv = tx_err;
      if (s_tready) break;
      low++; kk++;
      @(negedge clk);
    end
    expg = GAP + ((L < 60) ? 8 - nb : 0) + (anyerr ? 1 : 0);
    gtag = (L < 60) ? "R6 pad gap" : (anyerr ? "R13 error gap" : "R5 gap");
    check(low == expg, gtag, low, expg);
    check(errv == {4'b0000, e_over, e_last, e_mid, e_drop}, etag, errv,
          {4'b0000, e_over, e_last, e_mid, e_drop});
    t = 0;
    while (frames_seen == prev && t < 50) begin @(negedge clk); t++; end
    PL = (L < 60) ? 60 : L;
    F  = PL + 4;
    for (int i = 0; i < PL; i++) exp_f[i] = (i < L) ? pkt[i] : 8'h00;
    fcs = ref_crc(PL);
    if (corr) fcs = ~fcs;
    for (int i = 0; i < 4; i++) exp_f[PL + i] = fcs[8*i +: 8];
    check(frames_seen == prev + 1 && frame_len == F, "R2 frame length", frame_len, F);
    bad = 0; first_bad = -1;
    for (int i = 0; i < F; i++)
      if (got[i] !== exp_f[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    ftag = corr ? "R12 inverted FCS" : ((L < 60) ? "R3 padded frame" : "R4 frame bytes");
    if (first_bad < 0) check(1'b1, ftag, 0, 0);
    else check(1'b0, ftag, got[first_bad], exp_f[first_bad]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fs0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; linkup = 1'b0;
    s_tdata = '0; s_tkeep = 8'hFF; s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = 1'b0;
    repeat (5) @(negedge clk);
    check(s_tready == 1'b0 && m_tvalid == 1'b0 && tx_err == 8'h00, "R1 reset state",
          {s_tready, m_tvalid, tx_err}, 0);
    rst_n = 1'b1;
    s_tvalid = 1'b1; s_tlast = 1'b1;
    fs0 = frames_seen;
    repeat (10) @(negedge clk);
    check(s_tready == 1'b0 && frames_seen == fs0, "R1 link down holds tready", s_tready, 0);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    @(negedge clk);
    linkup = 1'b1;
    #1 check(s_tready == 1'b0, "R1 tready before edge", s_tready, 0);
    @(negedge clk);
    check(s_tready == 1'b1, "R1 tready after linkup", s_tready, 1);

    // Directed lengths around pad edge and every last-beat fill.
    send(60, -1, -1, 0, 0, "R7 clean report");
    send(59, -1, -1, 0, 0, "R7 clean report");
    send(1,  -1, -1, 0, 0, "R7 clean report");
    send(8,  -1, -1, 0, 0, "R7 clean report");
    for (int l = 61; l <= 72; l++) send(l, -1, -1, 0, 0, "R7 clean report");
    send(9014, -1, -1, 0, 0, "R11 at limit");
    send(9015, -1, -1, 0, 0, "R11 oversize");
    send(100, 3, -1, 0, 0, "R8 drop");
    send(20,  1, -1, 0, 0, "R8 drop short");
    send(100, -1, 2, 0, 0, "R9 mid keep");
    send(17,  -1, 0, 0, 0, "R9 mid keep short");
    send(70,  -1, -1, 8'h05, 0, "R10 last keep hole");
    send(64,  -1, -1, 8'h80, 0, "R10 last keep msb");
    send(90,  -1, -1, 0, 1, "R12 cancel");
    send(30,  -1, -1, 0, 1, "R12 cancel short");

    for (int r = 0; r < 40; r++) begin
      int len = (r % 3 == 0) ? 1 + int'($urandom % 59) : 60 + int'($urandom % 1400);
      send(len, -1, -1, 0, logic'($urandom % 4 == 0), "R7 random report");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule